// File: doc/BRIEF.md
# Speculation-Isolating Partitioned Cache Controller

This block is the tag and state controller of a set-associative cache. Each line in each set is labelled as either temporary or persistent. A line brought in by a speculative access goes into the temporary domain and belongs to the thread that caused it. Only a commit event turns it persistent. A squash event throws it away.

Any other thread sees an owned temporary line as absent. A probe by another thread therefore cannot tell that speculative work touched the cache. Persistent lines follow least-recently-used (LRU) replacement, which works only among persistent lines. A non-speculative fill can never displace a temporary line.

The cache is driven by three inputs:
- an access port, which gives a registered hit/miss and the line data;
- a fill port, through which the next-level memory (a fixed-latency stub) installs lines;
- an event port, which commits or squashes the temporary line tagged with a given access ID.

An address is `{tag, set index}`, with the set index in the low `log2(SETS)` bits.

Top module: `spec_part_cache`

## Requirements
- R1: After reset every line is invalid, so every access misses. For each cycle with `acc_vld` high, `rsp_vld` is high exactly one cycle later. `rsp_hit` is never high without `rsp_vld`.
- R2: An accepted fill with `fill_spec`=1 installs a temporary line owned by `fill_thr` and tagged `fill_id`. A later access by that same thread to the address hits and returns `fill_data`.
- R3: An access by a thread other than the owner of a temporary line reports a miss. It changes no state: the owner still hits afterwards.
- R4: A set holds at most `TMP_MAX` (default 2) temporary lines. A speculative fill into a set that is full of temporary lines raises `fill_stall` in the same cycle and is not taken. Speculative fills into other sets are not held. Once a squash frees a slot, the same fill is accepted.
- R5: A commit event (`ev_commit`=1) whose `ev_id` matches a temporary line makes that line persistent in place. Every thread then hits on it with unchanged data.
- R6: A squash event (`ev_commit`=0) whose `ev_id` matches invalidates that temporary line, so its owner then misses. Persistent lines are untouched.
- R7: A set holds at most `WAYS-TMP_MAX` (default 6) persistent lines. A commit into a set already at that count evicts the LRU persistent line in the same cycle.
- R8: A fill with `fill_spec`=0 installs a persistent line. It takes a free way while the set is below the persistent limit, and otherwise replaces the LRU persistent line. Temporary lines are never displaced.
- R9: A persistent line becomes most recently used when it is filled, promoted, or hit by a non-speculative access (`acc_spec`=0). A speculative access that hits leaves the recency order unchanged.
- R10: An event whose `ev_id` matches no temporary line has no effect. Any fill presented in the same cycle as an event is stalled (`fill_stall`=1) and not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access request valid |
| acc_spec | input | 1 | Access is speculative (does not update recency) |
| acc_thr | input | THR_W | Requesting thread |
| acc_addr | input | TAG_W+log2(SETS) | Access address |
| rsp_vld | output | 1 | Registered response valid |
| rsp_hit | output | 1 | Registered hit flag |
| rsp_data | output | DATA_W | Registered line data (meaningful on hit) |
| fill_vld | input | 1 | Fill valid |
| fill_spec | input | 1 | Fill installs a temporary line |
| fill_thr | input | THR_W | Owner thread of a temporary fill |
| fill_id | input | ID_W | Access ID carried by a temporary fill |
| fill_addr | input | TAG_W+log2(SETS) | Fill address |
| fill_data | input | DATA_W | Fill data |
| fill_stall | output | 1 | Fill not taken this cycle |
| ev_vld | input | 1 | Commit/squash event valid |
| ev_commit | input | 1 | 1 = commit, 0 = squash |
| ev_id | input | ID_W | Access ID the event refers to |

## Verification
A response is due on the first clock edge after the edge that samples `acc_vld`. The scoreboard's driver queues the expected hit and data as it presents the access. The monitor pops the queue at the following falling edge whenever `rsp_vld` is high.

`fill_stall` is combinational and is checked at the falling edge of the same cycle in which the fill is presented. The state change caused by a fill or an event takes effect on that cycle's rising edge. Its visible effect is therefore checked with an access issued on a later cycle. The bench never overlaps a state-changing operation with the access that observes it.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // State update chosen for one clock cycle; one update per cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_EVENT = 2'd1,
    OP_FILL  = 2'd2,
    OP_TOUCH = 2'd3
  } op_e;
endpackage

// File: rtl/spc_first.sv
module spc_first #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spc_lru_pick.sv
module spc_lru_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 3,
  localparam int IW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       cand,
  input  logic [WAYS*AGE_W-1:0] ages,
  output logic [IW-1:0]         victim
);
  logic [AGE_W-1:0] best_age;
  logic             seen;
  // oldest candidate; ties go to the lowest way
  always_comb begin
    victim   = '0;
    best_age = '0;
    seen     = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!seen || ages[i*AGE_W +: AGE_W] > best_age)) begin
        seen     = 1'b1;
        best_age = ages[i*AGE_W +: AGE_W];
        victim   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/spec_part_cache.sv
module spec_part_cache
  import spc_pkg::*;
#(
  parameter int SETS    = 4,
  parameter int WAYS    = 8,
  parameter int TMP_MAX = 2,
  parameter int TAG_W   = 8,
  parameter int DATA_W  = 16,
  parameter int THR_W   = 1,
  parameter int ID_W    = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_vld,
  input  logic              acc_spec,
  input  logic [THR_W-1:0]  acc_thr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              fill_vld,
  input  logic              fill_spec,
  input  logic [THR_W-1:0]  fill_thr,
  input  logic [ID_W-1:0]   fill_id,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_stall,
  input  logic              ev_vld,
  input  logic              ev_commit,
  input  logic [ID_W-1:0]   ev_id
);
  localparam int WAY_W = $clog2(WAYS);
  localparam int AGE_W = WAY_W;
  localparam int FL_W  = IDX_W + WAY_W;
  localparam int CNT_W = WAY_W + 1;
  localparam int TOT_W = FL_W + 1;
  localparam int P_MAX = WAYS - TMP_MAX;
  localparam logic [CNT_W-1:0] TMP_LIM  = CNT_W'(TMP_MAX);
  localparam logic [CNT_W-1:0] PERS_LIM = CNT_W'(P_MAX);
  localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(WAYS - 1);

  // per-line state
  logic [SETS-1:0][WAYS-1:0] v_q, t_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [THR_W-1:0] own_q [SETS][WAYS];
  logic [ID_W-1:0]  id_q  [SETS][WAYS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [DATA_W-1:0] dmem [SETS*WAYS];

  // access lookup
  logic [IDX_W-1:0] ai;
  logic [TAG_W-1:0] atag;
  logic [WAYS-1:0]  acc_match;
  logic             hit_found;
  logic [WAY_W-1:0] hit_w;
  assign ai   = acc_addr[IDX_W-1:0];
  assign atag = acc_addr[ADDR_W-1:IDX_W];
  always_comb
    for (int w = 0; w < WAYS; w++)
      acc_match[w] = v_q[ai][w] && tag_q[ai][w] == atag &&
                     (!t_q[ai][w] || own_q[ai][w] == acc_thr);
  spc_first #(.N(WAYS)) u_hit (.req(acc_match), .found(hit_found), .idx(hit_w));

  // fill set view
  logic [IDX_W-1:0]       fi;
  logic [TAG_W-1:0]       ftag;
  logic [WAYS-1:0]        f_free, f_pers;
  logic [WAYS*AGE_W-1:0]  f_ages;
  logic [CNT_W-1:0]       f_tcnt, f_pcnt;
  logic                   f_has_free, fill_go;
  logic [WAY_W-1:0]       f_free_w, f_vic, fw;
  assign fi   = fill_addr[IDX_W-1:0];
  assign ftag = fill_addr[ADDR_W-1:IDX_W];
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      f_free[w] = !v_q[fi][w];
      f_pers[w] = v_q[fi][w] && !t_q[fi][w];
      f_ages[w*AGE_W +: AGE_W] = age_q[fi][w];
    end
    f_tcnt = CNT_W'($countones(v_q[fi] & t_q[fi]));
    f_pcnt = CNT_W'($countones(f_pers));
  end
  spc_first    #(.N(WAYS)) u_free (.req(f_free), .found(f_has_free), .idx(f_free_w));
  spc_lru_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_fvic (.cand(f_pers), .ages(f_ages), .victim(f_vic));
  assign fill_stall = fill_vld && (ev_vld || (fill_spec && f_tcnt >= TMP_LIM));
  assign fill_go    = fill_vld && !fill_stall && (f_has_free || !fill_spec);
  assign fw         = (fill_spec || f_pcnt < PERS_LIM) ? f_free_w : f_vic;

  // event lookup over every line
  logic [SETS*WAYS-1:0]  ev_match;
  logic                  ev_found;
  logic [FL_W-1:0]       ev_flat;
  logic [IDX_W-1:0]      ev_s;
  logic [WAY_W-1:0]      ev_w, ev_vic;
  logic [WAYS-1:0]       ev_pers;
  logic [WAYS*AGE_W-1:0] ev_ages;
  logic [CNT_W-1:0]      ev_pcnt;
  always_comb
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        ev_match[s*WAYS + w] = v_q[s][w] && t_q[s][w] && id_q[s][w] == ev_id;
  spc_first #(.N(SETS*WAYS)) u_ev (.req(ev_match), .found(ev_found), .idx(ev_flat));
  assign ev_s = ev_flat[FL_W-1:WAY_W];
  assign ev_w = ev_flat[WAY_W-1:0];
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      ev_pers[w] = v_q[ev_s][w] && !t_q[ev_s][w];
      ev_ages[w*AGE_W +: AGE_W] = age_q[ev_s][w];
    end
    ev_pcnt = CNT_W'($countones(ev_pers));
  end
  spc_lru_pick #(.WAYS(WAYS), .AGE_W(AGE_W)) u_evic (.cand(ev_pers), .ages(ev_ages), .victim(ev_vic));

  // one state update per cycle: event, then fill, then recency touch
  op_e op;
  always_comb begin
    if (ev_vld)       op = ev_found ? OP_EVENT : OP_IDLE;
    else if (fill_go) op = OP_FILL;
    else if (acc_vld && !acc_spec && hit_found && !t_q[ai][hit_w]) op = OP_TOUCH;
    else              op = OP_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          v_q[s][w]   <= 1'b0;
          t_q[s][w]   <= 1'b0;
          age_q[s][w] <= '0;
        end
    end else begin
      case (op)
        OP_EVENT: begin
          if (ev_commit) begin
            for (int w = 0; w < WAYS; w++)
              if (ev_pers[w] && age_q[ev_s][w] != AGE_MAX)
                age_q[ev_s][w] <= age_q[ev_s][w] + 1'b1;
            t_q[ev_s][ev_w]   <= 1'b0;
            age_q[ev_s][ev_w] <= '0;
            if (ev_pcnt >= PERS_LIM) v_q[ev_s][ev_vic] <= 1'b0;
          end else begin
            v_q[ev_s][ev_w] <= 1'b0;
          end
        end
        OP_FILL: begin
          if (!fill_spec)
            for (int w = 0; w < WAYS; w++)
              if (f_pers[w] && age_q[fi][w] != AGE_MAX)
                age_q[fi][w] <= age_q[fi][w] + 1'b1;
          v_q[fi][fw]   <= 1'b1;
          t_q[fi][fw]   <= fill_spec;
          tag_q[fi][fw] <= ftag;
          own_q[fi][fw] <= fill_thr;
          id_q[fi][fw]  <= fill_id;
          age_q[fi][fw] <= '0;
        end
        OP_TOUCH: begin
          for (int w = 0; w < WAYS; w++)
            if (v_q[ai][w] && !t_q[ai][w] && age_q[ai][w] < age_q[ai][hit_w])
              age_q[ai][w] <= age_q[ai][w] + 1'b1;
          age_q[ai][hit_w] <= '0;
        end
        default: ;
      endcase
    end
  end

  // data array: write on fill, registered read
  always_ff @(posedge clk) begin
    if (fill_go) dmem[{fi, fw}] <= fill_data;
    rsp_data <= dmem[{ai, hit_w}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld <= 1'b0;
      rsp_hit <= 1'b0;
    end else begin
      rsp_vld <= acc_vld;
      rsp_hit <= acc_vld && hit_found;
    end
  end

  // ---------------- assertions ----------------
  logic [TOT_W-1:0] pers_total;
  assign pers_total = TOT_W'($countones(v_q & ~t_q));

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    // R4
    tmp_cap_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(v_q[s] & t_q[s]) <= TMP_MAX);
    // R7
    pers_cap_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(v_q[s] & ~t_q[s]) <= P_MAX);
  end

  // R1
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> rsp_vld);
  // R1
  rsp_hit_gated_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> !rsp_hit);
  // R6
  squash_keeps_pers_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && !ev_commit) |=> $stable(pers_total));
  // R10
  stray_event_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && !ev_found) |=> ($stable(v_q) && $stable(t_q)));
endmodule

// File: tb/sim_spec_part_cache.sv
`timescale 1ns/1ps
module sim_spec_part_cache;
  localparam int MEM_LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_vld = 0, acc_spec = 0;
  logic [0:0]  acc_thr = '0;
  logic [9:0]  acc_addr = '0;
  logic        rsp_vld, rsp_hit;
  logic [15:0] rsp_data;
  logic        fill_vld = 0, fill_spec = 0;
  logic [0:0]  fill_thr = '0;
  logic [3:0]  fill_id = '0;
  logic [9:0]  fill_addr = '0;
  logic [15:0] fill_data = '0;
  logic        fill_stall;
  logic        ev_vld = 0, ev_commit = 0;
  logic [3:0]  ev_id = '0;

  always #2.5 clk = ~clk;

  spec_part_cache u0 (
    .clk(clk), .rst(rst),
    .acc_vld(acc_vld), .acc_spec(acc_spec), .acc_thr(acc_thr), .acc_addr(acc_addr),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .fill_vld(fill_vld), .fill_spec(fill_spec), .fill_thr(fill_thr), .fill_id(fill_id),
    .fill_addr(fill_addr), .fill_data(fill_data), .fill_stall(fill_stall),
    .ev_vld(ev_vld), .ev_commit(ev_commit), .ev_id(ev_id)
  );

  typedef struct {
    logic        hit;
    logic [15:0] data;
    string       req;
  } exp_t;
  exp_t expq[$];
  int n_run = 0, n_fail = 0;

  function automatic logic [9:0] mk(input int tag, input int idx);
    return {8'(tag), 2'(idx)};
  endfunction
  function automatic logic [15:0] dat(input logic [9:0] a);
    return 16'h5A00 ^ {6'd0, a};
  endfunction

  // driver: access plus expected result into the scoreboard
  task automatic access(input logic [9:0] a, input logic thr, input logic spec,
                        input logic eh, input string req);
    exp_t e;
    @(posedge clk); #1;
    acc_vld = 1; acc_addr = a; acc_thr = thr; acc_spec = spec;
    e.hit = eh; e.data = dat(a); e.req = req;
    expq.push_back(e);
    @(posedge clk); #1;
    acc_vld = 0;
  endtask

  // next-level memory stub: fixed latency, then one fill attempt
  task automatic fill(input logic [9:0] a, input logic spec, input logic thr,
                      input int id, input logic exp_stall, input string req);
    repeat (MEM_LAT) @(posedge clk);
    #1;
    fill_vld = 1; fill_addr = a; fill_spec = spec; fill_thr = thr;
    fill_id = 4'(id); fill_data = dat(a);
    @(negedge clk);
    n_run++;
    if (fill_stall !== exp_stall) begin
      n_fail++;
      $display("FAIL %s: fill_stall=%0b expected %0b", req, fill_stall, exp_stall);
    end
    @(posedge clk); #1;
    fill_vld = 0;
  endtask

  task automatic event_op(input int id, input logic commit);
    @(posedge clk); #1;
    ev_vld = 1; ev_commit = commit; ev_id = 4'(id);
    @(posedge clk); #1;
    ev_vld = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_vld) begin
      exp_t e;
      n_run++;
      if (expq.size() == 0) begin
        n_fail++;
        $display("FAIL R1: unexpected response hit=%0b expected none", rsp_hit);
      end else begin
        e = expq.pop_front();
        if (rsp_hit !== e.hit) begin
          n_fail++;
          $display("FAIL %s: hit=%0b expected %0b", e.req, rsp_hit, e.hit);
        end else if (e.hit && rsp_data !== e.data) begin
          n_fail++;
          $display("FAIL %s: data=%h expected %h", e.req, rsp_data, e.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;

    // R1: nothing valid after reset
    access(mk(4, 0), 0, 0, 0, "R1 reset miss");

    // R2 / R3: speculative line, owner vs other thread
    fill(mk(1, 0), 1, 0, 1, 0, "R2 spec fill taken");
    access(mk(1, 0), 0, 1, 1, "R2 owner hit");
    access(mk(1, 0), 1, 0, 0, "R3 foreign miss");
    access(mk(1, 0), 0, 1, 1, "R3 owner still hits");

    // R4: temporary cap
    fill(mk(2, 0), 1, 1, 2, 0, "R4 second temp taken");
    fill(mk(3, 0), 1, 0, 3, 1, "R4 third temp stalled");
    access(mk(3, 0), 0, 1, 0, "R4 stalled fill not installed");
    fill(mk(7, 1), 1, 0, 4, 0, "R4 other set not held");
    event_op(4, 0);

    // R6: squash
    event_op(2, 0);
    access(mk(2, 0), 1, 1, 0, "R6 squashed line misses");
    fill(mk(3, 0), 1, 0, 3, 0, "R4 slot freed fill taken");

    // R5: commit
    event_op(1, 1);
    access(mk(1, 0), 1, 0, 1, "R5 committed line seen by other thread");

    // R10: stray event and event/fill collision
    event_op(9, 1);
    access(mk(3, 0), 0, 1, 1, "R10 stray event leaves temp line");
    @(posedge clk); #1;
    ev_vld = 1; ev_commit = 0; ev_id = 4'd15;
    fill_vld = 1; fill_spec = 0; fill_addr = mk(30, 3); fill_data = dat(mk(30, 3));
    @(negedge clk);
    n_run++;
    if (fill_stall !== 1'b1) begin
      n_fail++;
      $display("FAIL R10: fill_stall=%0b expected 1", fill_stall);
    end
    @(posedge clk); #1;
    ev_vld = 0; fill_vld = 0;
    access(mk(30, 3), 0, 0, 0, "R10 colliding fill not installed");

    // R8 / R9: persistent replacement in set 2 with one temp line
    fill(mk(20, 2), 1, 0, 5, 0, "R8 temp line in set 2");
    for (int t = 10; t < 16; t++) fill(mk(t, 2), 0, 0, 0, 0, "R8 persistent fill");
    access(mk(10, 2), 0, 0, 1, "R9 non-spec touch");
    access(mk(11, 2), 0, 1, 1, "R9 spec hit no touch");
    fill(mk(16, 2), 0, 0, 0, 0, "R8 fill at limit");
    access(mk(11, 2), 0, 1, 0, "R9 LRU line 11 evicted");
    access(mk(10, 2), 0, 1, 1, "R9 touched line kept");
    access(mk(16, 2), 0, 1, 1, "R8 new line present");
    access(mk(20, 2), 0, 1, 1, "R8 temp line not displaced");

    // R7: commit into a full persistent domain
    event_op(5, 1);
    access(mk(12, 2), 0, 1, 0, "R7 LRU line 12 evicted");
    access(mk(20, 2), 1, 1, 1, "R7 promoted line visible");
    access(mk(13, 2), 0, 1, 1, "R7 next line kept");

    repeat (4) @(posedge clk);
    n_run++;
    if (expq.size() != 0) begin
      n_fail++;
      $display("FAIL R1: %0d responses missing, expected 0", expq.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule